// File: doc/BRIEF.md
# Inset Window Raster Timing

This block places a rectangular inset picture on top of the main picture. Two free-running counters track where the main raster is. A pixel counter restarts on every main horizontal sync pulse. A line counter advances on each horizontal pulse and restarts on the main vertical sync pulse. Both counts are compared against programmable origin and size settings. From that comparison the block produces three signals: a picture-area flag, a border-ring flag, and the main/sub switch output that the video mixer uses to cut between the two sources.

For each position the block also decides what the mixer shows there. It is one of: the live sub-picture, a flat background fill, a muted (black) inset, or the border colour. It supplies the fill levels that go with that choice. It also derives the write enable for the sub-picture store from the display and freeze settings. Every control arrives as a static register value.

The horizontal and vertical size selects each scale their own axis independently. The vertical origin can be stretched by 1.2 when the main picture runs at a 50 Hz field rate.

Top module: `pip_overlay_timing`

## Requirements
- R1: While reset is asserted, win_act_o, brd_act_o and pip_sw_o are 0, src_o is 0 and all fill outputs are 0.
- R2: The pixel count restarts at column 0 after an hsync_i pulse. The line count advances by one on an hsync_i pulse and restarts at line 0, with column 0, on a vsync_i pulse, including when vsync_i and hsync_i are high together. Outputs for column c appear c+1 clocks after the edge that samples the sync pulse.
- R3: The picture area spans columns hpos+2 up to, but not including, hpos+2+PW. PW is width_i when hsize_i=0 and floor(3*width_i/4) when hsize_i=1.
- R4: The picture area spans lines VS+1 up to, but not including, VS+1+PH. PH is height_i when vsize_i=0 and floor(3*height_i/4) when vsize_i=1.
- R5: VS is floor(6*vpos_i/5) when both vpos50_en_i and main_50hz_i are 1, and vpos_i otherwise.
- R6: The border ring is two columns wide on the left and right of the picture area and one line tall above and below it. brd_act_o is high on the ring only when border_en_i=1, and it is never high together with win_act_o.
- R7: src_o codes are 0 none, 1 live, 2 background, 3 mute and 4 border. Inside the picture area, mute takes precedence over background, and background takes precedence over live. Code 4 is shown wherever brd_act_o is high.
- R8: Where src_o=4, the fill levels come from the edge_* inputs when border_indep_i=1 and from the back_* inputs otherwise. Where src_o=2 the fill levels come from the back_* inputs. Everywhere else the fill levels are 0.
- R9: With disp_en_i=0, win_act_o, brd_act_o, pip_sw_o and cap_en_o stay 0 and src_o is 0.
- R10: cap_en_o is high exactly when disp_en_i=1 and freeze_i=0.
- R11: pip_sw_o equals (win_act_o OR brd_act_o) delayed by sw_delay_i clocks; a setting of 0 gives no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Main horizontal sync pulse, one clock wide |
| vsync_i | input | 1 | Main vertical sync pulse, one clock wide |
| main_50hz_i | input | 1 | Main picture runs at 50 Hz field rate |
| disp_en_i | input | 1 | Inset display master enable |
| freeze_i | input | 1 | Stop sub-picture updates (still image) |
| hsize_i | input | 1 | Horizontal size select, 0 large, 1 small |
| vsize_i | input | 1 | Vertical size select, 0 large, 1 small |
| hpos_i | input | 8 | Window left origin in pixels |
| vpos_i | input | 8 | Window top origin in lines |
| width_i | input | 7 | Picture width in pixels at large size |
| height_i | input | 8 | Picture height in lines at large size |
| vpos50_en_i | input | 1 | Stretch vertical origin by 1.2 at 50 Hz |
| border_en_i | input | 1 | Border ring display enable |
| border_indep_i | input | 1 | Border uses its own fill levels |
| edge_y_i | input | 4 | Border luma level |
| edge_u_i | input | 3 | Border blue-difference level |
| edge_v_i | input | 3 | Border red-difference level |
| back_en_i | input | 1 | Fill picture area with background level |
| mute_i | input | 1 | Blank the picture area |
| back_y_i | input | 4 | Background luma level |
| back_u_i | input | 3 | Background blue-difference level |
| back_v_i | input | 3 | Background red-difference level |
| sw_delay_i | input | 4 | Switch output delay in clocks |
| win_act_o | output | 1 | Picture area active |
| brd_act_o | output | 1 | Border ring active |
| pip_sw_o | output | 1 | Delayed main/sub switch |
| cap_en_o | output | 1 | Sub-picture store write enable |
| src_o | output | 3 | Content source code |
| fill_y_o | output | 4 | Fill luma level |
| fill_u_o | output | 3 | Fill blue-difference level |
| fill_v_o | output | 3 | Fill red-difference level |

## Verification
The hardest case to reach from the ports is the switch delay interacting with the window edges. It only shows up when a long delay tap spans a window boundary that is itself shifted by a small size setting and a stretched vertical origin. The stimulus therefore runs whole frames under several combinations of size select, 50 Hz stretch, border and delay tap, including the longest tap. A predictor tracks the raster position and a 15-deep history of the expected window state, and checks every output on every clock. Degenerate windows are covered by separate frames: zero width and height, an origin near the end of a long line, and vertical and horizontal sync arriving on the same edge.

// File: rtl/pip_pkg.sv
package pip_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_LIVE = 3'd1,
    SRC_BACK = 3'd2,
    SRC_MUTE = 3'd3,
    SRC_EDGE = 3'd4
  } src_e;

  typedef struct packed {
    logic [3:0] y;
    logic [2:0] u;
    logic [2:0] v;
  } lvl_t;

endpackage

// File: rtl/pip_raster_cnt.sv
module pip_raster_cnt #(
  parameter int H_W = 10,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hsync,
  input  logic           vsync,
  output logic [H_W-1:0] h_cnt,
  output logic [V_W-1:0] v_cnt
);
  localparam logic [H_W-1:0] H_MAX = '1;
  localparam logic [V_W-1:0] V_MAX = '1;

  logic [H_W-1:0] h_nx;
  logic [V_W-1:0] v_nx;

  always_comb begin
    h_nx = h_cnt;
    v_nx = v_cnt;
    if (vsync) begin
      h_nx = '0;
      v_nx = '0;
    end else if (hsync) begin
      h_nx = '0;
      if (v_cnt != V_MAX) v_nx = v_cnt + 1'b1;
    end else if (h_cnt != H_MAX) begin
      h_nx = h_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_nx;
      v_cnt <= v_nx;
    end
  end

  p_hrestart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (h_cnt == '0));
  p_vrestart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (v_cnt == '0 && h_cnt == '0));

endmodule

// File: rtl/pip_window_cmp.sv
module pip_window_cmp
  import pip_pkg::*;
#(
  parameter int H_W   = 10,
  parameter int V_W   = 10,
  parameter int POS_W = 8,
  parameter int HSZ_W = 7,
  parameter int VSZ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [H_W-1:0]   h_cnt,
  input  logic [V_W-1:0]   v_cnt,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] vpos,
  input  logic [HSZ_W-1:0] width,
  input  logic [VSZ_W-1:0] height,
  input  logic             hsize,
  input  logic             vsize,
  input  logic             vpos50_en,
  input  logic             main_50hz,
  input  logic             disp_en,
  input  logic             border_en,
  input  logic             border_indep,
  input  logic             back_en,
  input  logic             mute,
  input  lvl_t             edge_lvl,
  input  lvl_t             back_lvl,
  output logic             win_act,
  output logic             brd_act,
  output src_e             src,
  output lvl_t             lvl
);
  localparam int PW3_W = HSZ_W + 2;
  localparam int PH3_W = VSZ_W + 2;
  localparam int VP6_W = POS_W + 3;
  localparam logic [VP6_W-1:0] DIV5 = VP6_W'(5);

  logic [PW3_W-1:0] w3;
  logic [PH3_W-1:0] h3;
  logic [VP6_W-1:0] v6, v12;
  logic [H_W-1:0]   hs, pw, px0, px1, wx1;
  logic [V_W-1:0]   vs, ph, py0, py1, wy1;
  logic             in_xp, in_xw, in_yp, in_yw, in_pic, in_ring;
  logic             win_nx, brd_nx;
  src_e             src_nx;
  lvl_t             lvl_nx;

  // size scaling: small size is three quarters of the large extent
  always_comb begin
    w3  = ({2'b00, width} << 1) + {2'b00, width};
    h3  = ({2'b00, height} << 1) + {2'b00, height};
    v6  = ({3'b000, vpos} << 2) + ({3'b000, vpos} << 1);
    v12 = v6 / DIV5;
    pw  = hsize ? H_W'(w3 >> 2) : H_W'(width);
    ph  = vsize ? V_W'(h3 >> 2) : V_W'(height);
    hs  = H_W'(hpos);
    vs  = (vpos50_en && main_50hz) ? V_W'(v12) : V_W'(vpos);
  end

  // geometry: two-pixel side columns, one-line top and bottom rows
  always_comb begin
    px0 = hs + H_W'(2);
    px1 = px0 + pw;
    wx1 = px1 + H_W'(2);
    py0 = vs + V_W'(1);
    py1 = py0 + ph;
    wy1 = py1 + V_W'(1);
    in_xp   = (h_cnt >= px0) && (h_cnt < px1);
    in_xw   = (h_cnt >= hs)  && (h_cnt < wx1);
    in_yp   = (v_cnt >= py0) && (v_cnt < py1);
    in_yw   = (v_cnt >= vs)  && (v_cnt < wy1);
    in_pic  = in_xp && in_yp;
    in_ring = in_xw && in_yw && !in_pic;
    win_nx  = disp_en && in_pic;
    brd_nx  = disp_en && border_en && in_ring;
  end

  always_comb begin
    src_nx = SRC_NONE;
    lvl_nx = '0;
    if (win_nx) begin
      if (mute) begin
        src_nx = SRC_MUTE;
      end else if (back_en) begin
        src_nx = SRC_BACK;
        lvl_nx = back_lvl;
      end else begin
        src_nx = SRC_LIVE;
      end
    end else if (brd_nx) begin
      src_nx = SRC_EDGE;
      lvl_nx = border_indep ? edge_lvl : back_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_act <= 1'b0;
      brd_act <= 1'b0;
      src     <= SRC_NONE;
      lvl     <= '0;
    end else begin
      win_act <= win_nx;
      brd_act <= brd_nx;
      src     <= src_nx;
      lvl     <= lvl_nx;
    end
  end

  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (!win_act && !brd_act && src == SRC_NONE));
  p_ring_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !border_en |=> !brd_act);
  p_edge_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EDGE) |-> (brd_act && !win_act));
  p_pic_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_LIVE || src == SRC_BACK || src == SRC_MUTE) |-> win_act);

endmodule

// File: rtl/pip_sw_delay.sv
module pip_sw_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [DLY_W-1:0] sel,
  output logic             dout
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [DEPTH:1] line_q;
  logic [DEPTH:1] line_nx;
  logic [DEPTH:0] tap;

  assign tap[0] = din;
  generate
    for (genvar i = 1; i <= DEPTH; i++) begin : g_tap
      assign tap[i] = line_q[i];
    end
  endgenerate

  always_comb begin
    line_nx = {line_q[DEPTH-1:1], din};
    dout    = tap[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_nx;
  end

endmodule

// File: rtl/pip_overlay_timing.sv
module pip_overlay_timing
  import pip_pkg::*;
#(
  parameter int H_W   = 10,
  parameter int V_W   = 10,
  parameter int POS_W = 8,
  parameter int HSZ_W = 7,
  parameter int VSZ_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             main_50hz_i,
  input  logic             disp_en_i,
  input  logic             freeze_i,
  input  logic             hsize_i,
  input  logic             vsize_i,
  input  logic [POS_W-1:0] hpos_i,
  input  logic [POS_W-1:0] vpos_i,
  input  logic [HSZ_W-1:0] width_i,
  input  logic [VSZ_W-1:0] height_i,
  input  logic             vpos50_en_i,
  input  logic             border_en_i,
  input  logic             border_indep_i,
  input  logic [3:0]       edge_y_i,
  input  logic [2:0]       edge_u_i,
  input  logic [2:0]       edge_v_i,
  input  logic             back_en_i,
  input  logic             mute_i,
  input  logic [3:0]       back_y_i,
  input  logic [2:0]       back_u_i,
  input  logic [2:0]       back_v_i,
  input  logic [DLY_W-1:0] sw_delay_i,
  output logic             win_act_o,
  output logic             brd_act_o,
  output logic             pip_sw_o,
  output logic             cap_en_o,
  output logic [2:0]       src_o,
  output logic [3:0]       fill_y_o,
  output logic [2:0]       fill_u_o,
  output logic [2:0]       fill_v_o
);
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  src_e           src;
  lvl_t           lvl, edge_lvl, back_lvl;
  logic           any_act;

  assign edge_lvl = '{y: edge_y_i, u: edge_u_i, v: edge_v_i};
  assign back_lvl = '{y: back_y_i, u: back_u_i, v: back_v_i};

  pip_raster_cnt #(.H_W(H_W), .V_W(V_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hsync(hsync_i), .vsync(vsync_i),
    .h_cnt(h_cnt), .v_cnt(v_cnt)
  );

  pip_window_cmp #(.H_W(H_W), .V_W(V_W), .POS_W(POS_W), .HSZ_W(HSZ_W),
                   .VSZ_W(VSZ_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .hpos(hpos_i), .vpos(vpos_i), .width(width_i), .height(height_i),
    .hsize(hsize_i), .vsize(vsize_i), .vpos50_en(vpos50_en_i),
    .main_50hz(main_50hz_i), .disp_en(disp_en_i), .border_en(border_en_i),
    .border_indep(border_indep_i), .back_en(back_en_i), .mute(mute_i),
    .edge_lvl(edge_lvl), .back_lvl(back_lvl),
    .win_act(win_act_o), .brd_act(brd_act_o), .src(src), .lvl(lvl)
  );

  assign any_act = win_act_o | brd_act_o;

  pip_sw_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(any_act), .sel(sw_delay_i),
    .dout(pip_sw_o)
  );

  assign cap_en_o = disp_en_i & ~freeze_i;
  assign src_o    = src;
  assign fill_y_o = lvl.y;
  assign fill_u_o = lvl.u;
  assign fill_v_o = lvl.v;

  p_sw_nodelay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_delay_i == '0) |-> (pip_sw_o == any_act));
  p_sw_onedelay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_delay_i == DLY_W'(1) && $past(sw_delay_i) == DLY_W'(1))
      |-> (pip_sw_o == $past(any_act)));

endmodule

// File: tb/sim_pip_overlay_timing.sv
module sim_pip_overlay_timing;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 0, vsync = 0, m50 = 0, disp = 0, frz = 0, hsz = 0, vsz = 0;
  logic [7:0] hpos = 0, vpos = 0, height = 0;
  logic [6:0] width = 0;
  logic v50en = 0, brd_en = 0, indep = 0, back_en = 0, mute = 0;
  logic [3:0] ey = 0, by = 0, dly = 0;
  logic [2:0] eu = 0, ev = 0, bu = 0, bv = 0;
  logic win, brd, psw, cap;
  logic [2:0] src, fu, fv;
  logic [3:0] fy;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pip_overlay_timing u0 (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .main_50hz_i(m50), .disp_en_i(disp), .freeze_i(frz), .hsize_i(hsz),
    .vsize_i(vsz), .hpos_i(hpos), .vpos_i(vpos), .width_i(width),
    .height_i(height), .vpos50_en_i(v50en), .border_en_i(brd_en),
    .border_indep_i(indep), .edge_y_i(ey), .edge_u_i(eu), .edge_v_i(ev),
    .back_en_i(back_en), .mute_i(mute), .back_y_i(by), .back_u_i(bu),
    .back_v_i(bv), .sw_delay_i(dly), .win_act_o(win), .brd_act_o(brd),
    .pip_sw_o(psw), .cap_en_o(cap), .src_o(src), .fill_y_o(fy),
    .fill_u_o(fu), .fill_v_o(fv)
  );

  typedef struct {
    bit win, brd, sw, cap;
    int src, y, u, v;
  } exp_t;

  exp_t q[$];
  int mh = 0, mv = 0;
  bit hist[16];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // predictor: expected outputs after this edge come from the raster
  // position held before the edge (R2)
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      mh = 0; mv = 0;
      foreach (hist[i]) hist[i] = 0;
    end else begin
      exp_t e;
      int hs, vs, pw, ph;
      bit xp, xw, yp, yw, pic, ring;
      hs = hpos;
      pw = hsz ? (int'(width) * 3) / 4 : int'(width);
      ph = vsz ? (int'(height) * 3) / 4 : int'(height);
      vs = (v50en && m50) ? (int'(vpos) * 6) / 5 : int'(vpos);
      xp = (mh >= hs + 2) && (mh < hs + 2 + pw);
      xw = (mh >= hs) && (mh < hs + 4 + pw);
      yp = (mv >= vs + 1) && (mv < vs + 1 + ph);
      yw = (mv >= vs) && (mv < vs + 2 + ph);
      pic = xp && yp;
      ring = xw && yw && !pic;
      e.win = disp && pic;
      e.brd = disp && brd_en && ring;
      e.src = 0; e.y = 0; e.u = 0; e.v = 0;
      if (e.win) begin
        if (mute) e.src = 3;
        else if (back_en) begin e.src = 2; e.y = by; e.u = bu; e.v = bv; end
        else e.src = 1;
      end else if (e.brd) begin
        e.src = 4;
        if (indep) begin e.y = ey; e.u = eu; e.v = ev; end
        else begin e.y = by; e.u = bu; e.v = bv; end
      end
      e.sw = (dly == 0) ? (e.win | e.brd) : hist[dly - 1];
      e.cap = disp && !frz;
      for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = e.win | e.brd;
      q.push_back(e);
      if (vsync) begin mh = 0; mv = 0; end
      else if (hsync) begin mh = 0; if (mv < 1023) mv = mv + 1; end
      else if (mh < 1023) mh = mh + 1;
    end
  end

  // monitor
  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(win == e.win, "R2 R3 R4 R5 win_act", win, e.win);
      check(brd == e.brd, "R6 brd_act", brd, e.brd);
      check(int'(src) == e.src, "R7 src", src, e.src);
      check(int'(fy) == e.y && int'(fu) == e.u && int'(fv) == e.v, "R8 fill",
            {fy, fu, fv}, (e.y << 6) | (e.u << 3) | e.v);
      check(psw == e.sw, "R11 pip_sw", psw, e.sw);
      check(cap == e.cap, "R10 cap_en", cap, e.cap);
    end
  end

  task automatic run_frame(input int lines, input int len, input bit both);
    for (int l = 0; l < lines; l++) begin
      @(negedge clk);
      if (l == 0) begin vsync = 1; hsync = both; end
      else hsync = 1;
      @(negedge clk);
      vsync = 0; hsync = 0;
      repeat (len - 2) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 2);
    // R1: reset state
    check(win == 0 && brd == 0 && psw == 0, "R1 flags", {win, brd, psw}, 0);
    check(src == 0 && fy == 0 && fu == 0 && fv == 0, "R1 src/fill",
          {src, fy, fu, fv}, 0);
    @(negedge clk);
    hpos = 4; vpos = 2; width = 8; height = 5; disp = 1; brd_en = 1;
    indep = 1; ey = 4'hC; eu = 3'd5; ev = 3'd6; by = 4'h3; bu = 3'd1; bv = 3'd2;
    rst_n = 1;
    run_frame(12, 24, 0);
    // small sizes, background fill, short switch delay
    hsz = 1; vsz = 1; back_en = 1; dly = 3;
    run_frame(12, 24, 0);
    // mute over background, shared border levels, longest delay
    mute = 1; indep = 0; dly = 15;
    run_frame(12, 24, 1);
    // 50 Hz origin stretch: 10 -> 12 (R5)
    mute = 0; back_en = 0; vpos = 10; v50en = 1; m50 = 1; dly = 2;
    run_frame(20, 24, 0);
    m50 = 0;
    run_frame(20, 24, 0);
    // border off (R6), freeze (R10)
    v50en = 0; vpos = 2; brd_en = 0; frz = 1; dly = 0;
    run_frame(10, 24, 0);
    // display off (R9)
    disp = 0; brd_en = 1;
    run_frame(10, 24, 0);
    #2;
    check(cap == 0 && win == 0 && psw == 0, "R9 display off",
          {cap, win, psw}, 0);
    // degenerate window: ring only
    disp = 1; frz = 0; hsz = 0; vsz = 0; width = 0; height = 0; dly = 1;
    run_frame(6, 24, 1);
    // far right origin, widest picture
    hpos = 250; vpos = 0; width = 7'd127; height = 2; dly = 5;
    run_frame(5, 400, 0);
    repeat (20) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule